// File: doc/BRIEF.md
# Data-Space-Aliased Register File Datapath

This block holds thirty-two 8-bit general registers and maps them onto the lowest thirty-two byte addresses of a 16-bit data space. Behind that window sits a 256-byte internal RAM. Addresses past the RAM read as zero. The register file is reached in three ways. First, a two-operand add is decoded directly from a 16-bit instruction word. Second, an indirect byte load takes its address from a 16-bit pointer held in a register pair. Third, an external master reads and writes the data space through a byte port.

Because the registers sit in the data space, an indirect load whose pointer lands below 32 copies one register into another. A master can also set up or inspect any register with ordinary data-space accesses. The add reports carry and zero on two flag outputs.

Top module: `rfm_core`

## Requirements
- R1: While `rst_n` is low, every register, both flags and `ds_rdata` are cleared to zero.
- R2: When `insn_valid` is high and `insn[15:10]` = 000011, the register selected by `insn[8:4]` takes the 8-bit sum of itself and the register selected by {`insn[9]`, `insn[3:0]`}. The sum is visible from the following cycle.
- R3: An add sets `flag_c` to the carry out of bit 7 and `flag_z` to 1 when the 8-bit sum is zero. No other operation changes either flag.
- R4: When `insn_valid` is high and `insn[15:11]` = 10010, the register selected by `insn[8:4]` receives the data-space byte at the address {R31, R30} + {`insn[10:9]`, `insn[3:0]`}. The displacement is unsigned, and the 16-bit address wraps.
- R5: Data-space addresses 0 to 31 read and write the register with that index, so a load with a pointer below 32 moves one register into another.
- R6: Addresses 32 to 287 reach RAM byte (address − 32). Addresses 288 and above read as zero and ignore writes.
- R7: `ds_rdata` updates on the clock edge where `ds_en` is high and `ds_we` is low, and it holds its value on every other edge.
- R8: A read of a register in the same cycle that register is written returns the value it had before the write. This applies to add operands, load sources and port reads.
- R9: When an instruction and a port write target the same register in the same cycle, the instruction result is kept.
- R10: With `insn_valid` low, or with an opcode other than the add or the load, the instruction input changes no register and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_valid | input | 1 | Instruction word valid this cycle |
| insn | input | 16 | Instruction word |
| ds_en | input | 1 | Data-space access request |
| ds_we | input | 1 | 1 = write, 0 = read |
| ds_addr | input | 16 | Data-space byte address |
| ds_wdata | input | 8 | Write data |
| ds_rdata | output | 8 | Registered read data |
| flag_c | output | 1 | Carry of the last add |
| flag_z | output | 1 | Zero of the last add |

## Verification
Every result in this block is due exactly one clock edge after its stimulus. This covers a register written by an add or a load, the two flags, and `ds_rdata` after a port read. A register's new value is therefore seen through a port read issued in the following cycle, which returns it one edge after that.

The bench drives inputs on the falling edge and applies the same update to its reference model. It then samples the flags and the read data 2 ns after the next rising edge. Same-cycle collisions are driven together in one step, and the model resolves them only from pre-edge state.

// File: rtl/rfm_pkg.sv
// Shared encodings for the aliased register file datapath.
// Assumes 16-bit instruction words and 5-bit register indices.
package rfm_pkg;
    localparam int INSN_W = 16;
    localparam int IDX_W  = 5;
    localparam int DISP_W = 6;

    localparam logic [5:0] OP_ADD = 6'b000011; // insn[15:10]
    localparam logic [4:0] OP_LD  = 5'b10010;  // insn[15:11]

    // Where a data-space address lands.
    typedef enum logic [1:0] {
        REG_WIN = 2'd0,
        RAM_WIN = 2'd1,
        NO_WIN  = 2'd2
    } region_e;

    // Fields pulled out of one instruction word.
    typedef struct packed {
        logic              is_add;
        logic              is_ld;
        logic [IDX_W-1:0]  dst;
        logic [IDX_W-1:0]  src;
        logic [DISP_W-1:0] disp;
    } dec_t;
endpackage

// File: rtl/rfm_decode.sv
// Instruction decoder: splits a 16-bit word into add / load controls.
// Assumes fixed field positions; no state, purely combinational.
module rfm_decode
    import rfm_pkg::*;
(
    input  logic              valid,
    input  logic [INSN_W-1:0] word,
    output dec_t              dec
);
    // Field extraction and opcode match.
    always_comb begin
        dec.is_add = valid && (word[15:10] == OP_ADD);
        dec.is_ld  = valid && (word[15:11] == OP_LD);
        dec.dst    = word[8:4];
        dec.src    = {word[9], word[3:0]};
        dec.disp   = {word[10:9], word[3:0]};
    end
endmodule

// File: rtl/rfm_adder.sv
// Byte adder producing sum, carry-out and zero indication.
// Assumes unsigned operands of width DW.
module rfm_adder #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] sum,
    output logic          cout,
    output logic          zero
);
    // Widened add so the carry appears in the top bit.
    always_comb begin
        {cout, sum} = {1'b0, a} + {1'b0, b};
        zero        = (sum == '0);
    end
endmodule

// File: rtl/rfm_regfile.sv
// Register array with NRD combinational read ports and two write ports.
// Port A (instruction) has priority over port B (external) on the same entry.
// Reads return pre-edge contents; the pointer pair is exported directly.
module rfm_regfile #(
    parameter int DW   = 8,
    parameter int NREG = 32,
    parameter int NRD  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NRD-1:0][IDXW-1:0]   rd_idx,
    output logic [NRD-1:0][DW-1:0]     rd_data,
    output logic [DW-1:0]              ptr_lo,
    output logic [DW-1:0]              ptr_hi,
    input  logic                       wa_en,
    input  logic [IDXW-1:0]            wa_idx,
    input  logic [DW-1:0]              wa_data,
    input  logic                       wb_en,
    input  logic [IDXW-1:0]            wb_idx,
    input  logic [DW-1:0]              wb_data
);
    localparam int IDXW = $clog2(NREG);

    logic [DW-1:0] mem [NREG];

    generate
        for (genvar e = 0; e < NREG; e++) begin : g_ent
            // One entry: reset, then port A before port B.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mem[e] <= '0;
                else if (wa_en && (wa_idx == IDXW'(e)))
                    mem[e] <= wa_data;
                else if (wb_en && (wb_idx == IDXW'(e)))
                    mem[e] <= wb_data;
            end
        end
        for (genvar p = 0; p < NRD; p++) begin : g_rd
            assign rd_data[p] = mem[rd_idx[p]];
        end
    endgenerate

    assign ptr_lo = mem[NREG-2];
    assign ptr_hi = mem[NREG-1];
endmodule

// File: rtl/rfm_ram.sv
// Internal data RAM: one write port, two combinational read ports.
// Contents are not reset; callers write before they read.
module rfm_ram #(
    parameter int DW    = 8,
    parameter int DEPTH = 256
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW_R-1:0]  waddr,
    input  logic [DW-1:0]    wdata,
    input  logic [AW_R-1:0]  raddr0,
    output logic [DW-1:0]    rdata0,
    input  logic [AW_R-1:0]  raddr1,
    output logic [DW-1:0]    rdata1
);
    localparam int AW_R = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];

    // Byte write.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata0 = mem[raddr0];
    assign rdata1 = mem[raddr1];
endmodule

// File: rtl/rfm_core.sv
// Top: register file aliased at data-space 0..NREG-1, RAM behind it,
// zero beyond. Executes a register add and a pointer-indirect load, and
// serves an external byte port with one-cycle registered read data.
// Assumes AW == 2*DW so the register pair forms one full address.
module rfm_core
    import rfm_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 8,
    parameter int NREG      = 32,
    parameter int RAM_DEPTH = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_valid,
    input  logic [15:0]       insn,
    input  logic              ds_en,
    input  logic              ds_we,
    input  logic [AW-1:0]     ds_addr,
    input  logic [DW-1:0]     ds_wdata,
    output logic [DW-1:0]     ds_rdata,
    output logic              flag_c,
    output logic              flag_z
);
    localparam int IDXW     = $clog2(NREG);
    localparam int RAMAW    = $clog2(RAM_DEPTH);
    localparam int RAM_BASE = NREG;
    localparam int RAM_END  = NREG + RAM_DEPTH;
    localparam int NRD      = 4;

    // Classify a data-space address.
    function automatic region_e region_of(input logic [AW-1:0] a);
        if (a < AW'(RAM_BASE))
            return REG_WIN;
        else if (a < AW'(RAM_END))
            return RAM_WIN;
        else
            return NO_WIN;
    endfunction

    dec_t                   dec;
    logic [NRD-1:0][IDXW-1:0] rd_idx;
    logic [NRD-1:0][DW-1:0]   rd_data;
    logic [DW-1:0]          ptr_lo, ptr_hi;
    logic [DW-1:0]          sum;
    logic                   cout, zero;
    logic [AW-1:0]          ld_addr;
    logic [AW-1:0]          ld_off, ds_off;
    region_e                ld_reg, ds_reg;
    logic [DW-1:0]          ram_ld, ram_ds;
    logic [DW-1:0]          ld_val, ds_val;
    logic                   wa_en, wb_en, ram_we;
    logic [DW-1:0]          wa_data;

    rfm_decode u_dec (
        .valid (insn_valid),
        .word  (insn),
        .dec   (dec)
    );

    // Read port map: 0 add dest, 1 add source, 2 load source, 3 port.
    always_comb begin
        rd_idx[0] = dec.dst;
        rd_idx[1] = dec.src;
        rd_idx[2] = ld_addr[IDXW-1:0];
        rd_idx[3] = ds_addr[IDXW-1:0];
    end

    rfm_regfile #(.DW(DW), .NREG(NREG), .NRD(NRD)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .ptr_lo  (ptr_lo),
        .ptr_hi  (ptr_hi),
        .wa_en   (wa_en),
        .wa_idx  (dec.dst),
        .wa_data (wa_data),
        .wb_en   (wb_en),
        .wb_idx  (ds_addr[IDXW-1:0]),
        .wb_data (ds_wdata)
    );

    rfm_adder #(.DW(DW)) u_add (
        .a    (rd_data[0]),
        .b    (rd_data[1]),
        .sum  (sum),
        .cout (cout),
        .zero (zero)
    );

    // Load address generation and region decode for both requesters.
    always_comb begin
        ld_addr = {ptr_hi, ptr_lo} + AW'(dec.disp);
        ld_reg  = region_of(ld_addr);
        ds_reg  = region_of(ds_addr);
        ld_off  = ld_addr - AW'(RAM_BASE);
        ds_off  = ds_addr - AW'(RAM_BASE);
    end

    rfm_ram #(.DW(DW), .DEPTH(RAM_DEPTH)) u_ram (
        .clk    (clk),
        .we     (ram_we),
        .waddr  (ds_off[RAMAW-1:0]),
        .wdata  (ds_wdata),
        .raddr0 (ld_off[RAMAW-1:0]),
        .rdata0 (ram_ld),
        .raddr1 (ds_off[RAMAW-1:0]),
        .rdata1 (ram_ds)
    );

    // Read data muxes, write enables and instruction write data.
    always_comb begin
        unique case (ld_reg)
            REG_WIN: ld_val = rd_data[2];
            RAM_WIN: ld_val = ram_ld;
            default: ld_val = '0;
        endcase
        unique case (ds_reg)
            REG_WIN: ds_val = rd_data[3];
            RAM_WIN: ds_val = ram_ds;
            default: ds_val = '0;
        endcase
        wa_en   = dec.is_add || dec.is_ld;
        wa_data = dec.is_add ? sum : ld_val;
        wb_en   = ds_en && ds_we && (ds_reg == REG_WIN);
        ram_we  = ds_en && ds_we && (ds_reg == RAM_WIN);
    end

    // Registered port read data.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ds_rdata <= '0;
        else if (ds_en && !ds_we)
            ds_rdata <= ds_val;
    end

    // Flags follow adds only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_c <= 1'b0;
            flag_z <= 1'b0;
        end else if (dec.is_add) begin
            flag_c <= cout;
            flag_z <= zero;
        end
    end
endmodule

// File: rtl/rfm_core_chk.sv
// Property checker for rfm_core, attached by bind below.
// Observes top-level ports only.
module rfm_core_chk #(
    parameter int AW        = 16,
    parameter int DW        = 8,
    parameter int NREG      = 32,
    parameter int RAM_DEPTH = 256
) (
    input logic          clk,
    input logic          rst_n,
    input logic          insn_valid,
    input logic [15:0]   insn,
    input logic          ds_en,
    input logic          ds_we,
    input logic [AW-1:0] ds_addr,
    input logic [DW-1:0] ds_rdata,
    input logic          flag_c,
    input logic          flag_z
);
    localparam int RAM_END = NREG + RAM_DEPTH;

    // R1: a reset cycle leaves flags and read data at zero.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (ds_rdata == '0 && !flag_c && !flag_z));

    // R3: non-add instruction words leave the flags alone.
    a_r3_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && insn[15:10] != 6'b000011) |=> $stable({flag_c, flag_z}));

    // R10: an idle instruction input leaves the flags alone.
    a_r10_idle_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_valid |=> $stable({flag_c, flag_z}));

    // R7: read data changes only after a port read.
    a_r7_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(ds_en && !ds_we) |=> $stable(ds_rdata));

    // R6: reads past the RAM return zero.
    a_r6_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_en && !ds_we && ds_addr >= AW'(RAM_END)) |=> ds_rdata == '0);
endmodule

bind rfm_core rfm_core_chk #(
    .AW(AW), .DW(DW), .NREG(NREG), .RAM_DEPTH(RAM_DEPTH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .insn_valid (insn_valid),
    .insn       (insn),
    .ds_en      (ds_en),
    .ds_we      (ds_we),
    .ds_addr    (ds_addr),
    .ds_rdata   (ds_rdata),
    .flag_c     (flag_c),
    .flag_z     (flag_z)
);

// File: tb/rfm_core_tb.sv
// Self-checking bench: directed corners plus seeded random traffic,
// compared against a reference model kept in bench variables.
module rfm_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [15:0] insn = '0;
    logic        ds_en = 1'b0;
    logic        ds_we = 1'b0;
    logic [15:0] ds_addr = '0;
    logic [7:0]  ds_wdata = '0;
    logic [7:0]  ds_rdata;
    logic        flag_c, flag_z;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [7:0] m_reg [32];
    logic [7:0] m_ram [256];
    logic       m_c = 0, m_z = 0;
    logic [7:0] m_rd = '0;

    always #4 clk = ~clk; // 125 MHz

    rfm_core u_dut (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
        .ds_en(ds_en), .ds_we(ds_we), .ds_addr(ds_addr), .ds_wdata(ds_wdata),
        .ds_rdata(ds_rdata), .flag_c(flag_c), .flag_z(flag_z)
    );

    function automatic logic [15:0] enc_add(input logic [4:0] d, input logic [4:0] s);
        return {6'b000011, s[4], d, s[3:0]};
    endfunction

    function automatic logic [15:0] enc_ld(input logic [4:0] d, input logic [5:0] disp);
        return {5'b10010, disp[5:4], d, disp[3:0]};
    endfunction

    // Reference read of the data space (R5, R6).
    function automatic logic [7:0] peek(input logic [15:0] a);
        if (a < 16'd32) return m_reg[a[4:0]];
        if (a < 16'd288) return m_ram[8'(a - 16'd32)];
        return 8'h00;
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // One cycle: drive at negedge, update the model, sample 2 ns after posedge.
    task automatic step(input string tag, input bit iv, input logic [15:0] iw,
                        input bit en, input bit we, input logic [15:0] a,
                        input logic [7:0] wd);
        logic [4:0] d, s;
        logic [8:0] s9;
        logic [7:0] val;
        logic [15:0] la;
        bit wr_i;
        logic nc, nz;
        insn_valid = iv; insn = iw; ds_en = en; ds_we = we; ds_addr = a; ds_wdata = wd;
        d = iw[8:4]; s = {iw[9], iw[3:0]}; wr_i = 0; val = '0; nc = m_c; nz = m_z;
        if (iv && iw[15:10] == 6'b000011) begin
            s9 = {1'b0, m_reg[d]} + {1'b0, m_reg[s]};
            val = s9[7:0]; nc = s9[8]; nz = (s9[7:0] == 8'h00); wr_i = 1;
        end else if (iv && iw[15:11] == 5'b10010) begin
            la = {m_reg[31], m_reg[30]} + {10'd0, iw[10:9], iw[3:0]};
            val = peek(la); wr_i = 1;
        end
        if (en && !we) m_rd = peek(a);
        if (en && we) begin
            if (a < 16'd32) begin
                if (!(wr_i && d == a[4:0])) m_reg[a[4:0]] = wd; // R9
            end else if (a < 16'd288) m_ram[8'(a - 16'd32)] = wd;
        end
        if (wr_i) m_reg[d] = val;
        m_c = nc; m_z = nz;
        @(posedge clk); #2;
        chk({tag, " R3 flags"}, {6'd0, flag_c, flag_z}, {6'd0, m_c, m_z});
        chk({tag, " R7 rdata"}, ds_rdata, m_rd);
        @(negedge clk);
    endtask

    task automatic wr(input string tag, input logic [15:0] a, input logic [7:0] v);
        step(tag, 0, '0, 1, 1, a, v);
    endtask

    task automatic rd(input string tag, input logic [15:0] a);
        step(tag, 0, '0, 1, 0, a, '0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 32; i++) m_reg[i] = '0;
        for (int i = 0; i < 256; i++) m_ram[i] = '0;
        repeat (3) @(posedge clk);
        #2;
        chk("R1 flags", {6'd0, flag_c, flag_z}, 8'h00);
        chk("R1 rdata", ds_rdata, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 32; i++) rd("R1 reg zero", 16'(i));
        for (int i = 0; i < 256; i++) wr("R6 ram fill", 16'(32 + i), 8'($urandom));
        rd("R6 ram low", 16'd32);
        rd("R6 ram top", 16'd287);
        wr("R6 ignored write", 16'd288, 8'hAA);
        rd("R6 zero read", 16'd288);
        rd("R6 zero read far", 16'hFFFF);
        // R2/R3 carry without zero
        wr("R2 setup", 16'd1, 8'hF0); wr("R2 setup", 16'd2, 8'h20);
        step("R2 add carry", 1, enc_add(5'd1, 5'd2), 0, 0, '0, '0);
        rd("R2 result", 16'd1);
        // R3 carry and zero
        wr("R3 setup", 16'd3, 8'h80); wr("R3 setup", 16'd4, 8'h80);
        step("R3 add zero", 1, enc_add(5'd3, 5'd4), 0, 0, '0, '0);
        rd("R3 result", 16'd3);
        // R2 source index above 15 uses bit 9
        wr("R2 setup", 16'd20, 8'h05);
        step("R2 high src", 1, enc_add(5'd2, 5'd20), 0, 0, '0, '0);
        rd("R2 high src result", 16'd2);
        // R5 register move through the pointer
        wr("R5 setup", 16'd5, 8'h5A); wr("R5 ptr hi", 16'd31, 8'h00); wr("R5 ptr lo", 16'd30, 8'h02);
        step("R5 load move", 1, enc_ld(5'd7, 6'd3), 0, 0, '0, '0);
        rd("R5 moved", 16'd7);
        // R4 load from RAM with displacement and from empty space
        wr("R4 ptr lo", 16'd30, 8'h30);
        step("R4 load ram", 1, enc_ld(5'd8, 6'd63), 0, 0, '0, '0);
        rd("R4 ram loaded", 16'd8);
        wr("R4 ptr hi", 16'd31, 8'hFF); wr("R4 ptr lo", 16'd30, 8'hFF);
        step("R4 load wrap", 1, enc_ld(5'd9, 6'd1), 0, 0, '0, '0);
        rd("R4 wrapped", 16'd9);
        wr("R4 ptr hi", 16'd31, 8'h02);
        step("R4 load none", 1, enc_ld(5'd9, 6'd5), 0, 0, '0, '0);
        rd("R4 none zero", 16'd9);
        // R8 same-cycle read of a register being written
        step("R8 read old", 1, enc_add(5'd1, 5'd1), 1, 0, 16'd1, '0);
        rd("R8 new value", 16'd1);
        // R9 instruction beats port write
        step("R9 collide", 1, enc_add(5'd4, 5'd5), 1, 1, 16'd4, 8'h77);
        rd("R9 kept", 16'd4);
        // R10 invalid and unknown words
        step("R10 invalid", 0, enc_add(5'd5, 5'd5), 0, 0, '0, '0);
        step("R10 unknown op", 1, 16'hC155, 0, 0, '0, '0);
        rd("R10 untouched", 16'd5);
        // Random mix
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] iw, a;
            bit iv, en, we;
            int k, j;
            k = int'($urandom % 8); j = int'($urandom % 9);
            iv = 1; iw = 16'($urandom);
            if (k < 3) iw = enc_add(5'($urandom), 5'($urandom));
            else if (k < 5) iw = enc_ld(5'($urandom % 30), 6'($urandom));
            else if (k == 5) iw[15:14] = 2'b11;
            else iv = 0;
            en = 1; we = 0; a = '0;
            case (j)
                0: en = 0;
                1: begin we = 1; a = 16'($urandom % 32); end
                2: begin we = 1; a = 16'(32 + $urandom % 256); end
                3: begin we = 1; a = 16'd31; end
                4: a = 16'($urandom % 32);
                5: a = 16'(32 + $urandom % 256);
                6: a = 16'($urandom % 600);
                7: begin we = 1; a = 16'($urandom % 600); end
                default: begin we = 1; a = 16'd30; end
            endcase
            step("R2 R4 R8 R9 random", iv, iw, en, we, a,
                 (j == 3) ? 8'($urandom % 3) : 8'($urandom));
        end
        for (int i = 0; i < 32; i++) rd("R5 final reg", 16'(i));
        for (int i = 0; i < 256; i += 7) rd("R6 final ram", 16'(32 + i));
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule